// File: doc/BRIEF.md
# MII to 4B/5B Transmit Encoder

This block sits between an Ethernet MAC's nibble-wide transmit interface and a downstream link transmitter that carries 5-bit line symbols. It wraps each packet from the MAC in a start delimiter pair and an end delimiter pair. It encodes every payload nibble with the 4B/5B data code, or replaces it with a HALT symbol when the MAC flags it as errored. The symbols go into a small synchronous FIFO, which the link transmitter drains with a read strobe.

The MAC is paced by a registered ready output. The block samples the MAC inputs only in a cycle where ready is high; such a cycle is called a step. After any step that writes a symbol, ready is low for at least one cycle. Ready is also held low while the link is not synchronised, and while the FIFO could not take a further delimiter pair. While ready is low, the MAC keeps its nibble, enable and error lines unchanged.

The controller has four states:
- ST_IDLE waits for enable. A step with enable high writes J and moves to ST_SEND_K.
- ST_SEND_K writes K on its next step, whatever the enable level, and moves to ST_PAYLOAD.
- ST_PAYLOAD writes one data or HALT symbol per step while enable is high. A step with enable low writes T and moves to ST_SEND_R.
- ST_SEND_R writes R on its next step and returns to ST_IDLE.

Steps in ST_IDLE with enable low write nothing.

Top module: `mii_4b5b_tx_enc`

## Requirements
- R1: While reset is high and in the first cycle after it, mac_ready is 0, sym_valid is 0 and sym_out is 5'b11111.
- R2: mac_ready is 0 in every cycle that follows a cycle with link_sync low. With link_sync low, no symbol is written even if mac_txen is held high. mac_ready becomes 1 one cycle after link_sync rises while the FIFO is empty.
- R3: In the cycle after any step that writes a symbol, mac_ready is 0. Inputs presented while mac_ready is 0 are not sampled.
- R4: The first step of a packet, which is the first with mac_txen high in ST_IDLE, writes J = 5'b11000. The next step writes K = 5'b10001. mac_txd is ignored in both steps.
- R5: A step in ST_PAYLOAD with mac_txen high and mac_txer low writes the 4B/5B code of mac_txd. The codes for nibbles 0 to F are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R6: A step in ST_PAYLOAD with mac_txen and mac_txer both high writes HALT = 5'b00100.
- R7: The first step in ST_PAYLOAD with mac_txen low writes T = 5'b01101. The next step writes R = 5'b00111. mac_txd is ignored in both steps.
- R8: If mac_txen is high for only one or two steps, the output is exactly J, K, T, R.
- R9: mac_ready is 0 whenever fewer than 3 FIFO entries would be free. The 16-entry FIFO never overflows, so no symbol is lost or reordered. With the reader stopped, filling stops at 14 entries.
- R10: When the FIFO is empty, sym_out is 5'b11111 and sym_valid is 0. Otherwise sym_out shows the oldest symbol, and a cycle with rd_strobe high pops it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_sync | input | 1 | Link frame synchronisation reached |
| mac_txd | input | 4 | Transmit nibble from the MAC |
| mac_txen | input | 1 | Transmit enable from the MAC |
| mac_txer | input | 1 | Transmit error flag from the MAC |
| mac_ready | output | 1 | Block will sample the MAC inputs this cycle |
| rd_strobe | input | 1 | Downstream pops one symbol |
| sym_out | output | 5 | Oldest buffered symbol, or IDLE when empty |
| sym_valid | output | 1 | sym_out holds a buffered symbol |

## Verification
The bench goes after packets with enable high for only one or two steps. A design that failed to complete the J/K pair would skip K or emit T early, and the output stream would differ from J, K, T, R. The MAC holds its inputs through every low-ready cycle and changes them only after a step, and it drives random nibbles during delimiter steps. A design that sampled while not ready, or that encoded delimiter-cycle data, would therefore show extra or wrong symbols. A long packet is sent with the reader stopped. A wrong headroom threshold would show a buffer level other than 14, and an overflow would lose symbols when the buffer drains.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;
    localparam int NIB_W = 4;
    localparam int SYM_W = 5;

    localparam logic [SYM_W-1:0] SYM_J    = 5'b11000;
    localparam logic [SYM_W-1:0] SYM_K    = 5'b10001;
    localparam logic [SYM_W-1:0] SYM_T    = 5'b01101;
    localparam logic [SYM_W-1:0] SYM_R    = 5'b00111;
    localparam logic [SYM_W-1:0] SYM_HALT = 5'b00100;
    localparam logic [SYM_W-1:0] SYM_IDLE = 5'b11111;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND_K,
        ST_PAYLOAD,
        ST_SEND_R
    } tx_state_t;
endpackage

// File: rtl/nibble_4b5b.sv
module nibble_4b5b
    import mii_tx_pkg::*;
(
    input  logic [NIB_W-1:0] nib,
    output logic [SYM_W-1:0] code
);
    always_comb begin
        unique case (nib)
            4'h0: code = 5'b11110;
            4'h1: code = 5'b01001;
            4'h2: code = 5'b10100;
            4'h3: code = 5'b10101;
            4'h4: code = 5'b01010;
            4'h5: code = 5'b01011;
            4'h6: code = 5'b01110;
            4'h7: code = 5'b01111;
            4'h8: code = 5'b10010;
            4'h9: code = 5'b10011;
            4'hA: code = 5'b10110;
            4'hB: code = 5'b10111;
            4'hC: code = 5'b11010;
            4'hD: code = 5'b11011;
            4'hE: code = 5'b11100;
            default: code = 5'b11101;
        endcase
    end
endmodule

// File: rtl/sym_fifo.sv
// Synchronous FIFO with show-ahead read; DEPTH must be a power of two.
module sym_fifo #(
    parameter int W     = 5,
    parameter int DEPTH = 16,
    parameter logic [W-1:0] EMPTY_VAL = '1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [W-1:0]               wr_data,
    input  logic                       rd_en,
    output logic [W-1:0]               rd_data,
    output logic                       empty,
    output logic [$clog2(DEPTH):0]     level,
    output logic [$clog2(DEPTH):0]     level_nx
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic          pop;

    assign empty   = (level == '0);
    assign pop     = rd_en && !empty;
    assign rd_data = empty ? EMPTY_VAL : mem[rptr];

    always_comb begin
        unique case ({wr_en, pop})
            2'b10:   level_nx = level + 1'b1;
            2'b01:   level_nx = level - 1'b1;
            default: level_nx = level;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            level <= level_nx;
            if (wr_en) wptr <= wptr + 1'b1;
            if (pop)   rptr <= rptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wptr] <= wr_data;
    end
endmodule

// File: rtl/mii_tx_ctrl.sv
module mii_tx_ctrl
    import mii_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             link_sync,
    input  logic             txen,
    input  logic             txer,
    input  logic [SYM_W-1:0] data_code,
    input  logic             room_ok,
    output logic             ready,
    output logic             wr_en,
    output logic [SYM_W-1:0] wr_sym,
    output tx_state_t        state
);
    tx_state_t state_nx;
    logic      ready_nx;

    // State register and registered ready.
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            ready <= 1'b0;
        end else begin
            state <= state_nx;
            ready <= ready_nx;
        end
    end

    // Transitions: only a step (ready high) moves the machine.
    always_comb begin
        state_nx = state;
        if (ready) begin
            unique case (state)
                ST_IDLE:    if (txen) state_nx = ST_SEND_K;
                ST_SEND_K:  state_nx = ST_PAYLOAD;
                ST_PAYLOAD: if (!txen) state_nx = ST_SEND_R;
                ST_SEND_R:  state_nx = ST_IDLE;
                default:    state_nx = ST_IDLE;
            endcase
        end
    end

    // Outputs: symbol written in this step.
    always_comb begin
        wr_en  = 1'b0;
        wr_sym = SYM_IDLE;
        if (ready) begin
            unique case (state)
                ST_IDLE: begin
                    wr_en  = txen;
                    wr_sym = SYM_J;
                end
                ST_SEND_K: begin
                    wr_en  = 1'b1;
                    wr_sym = SYM_K;
                end
                ST_PAYLOAD: begin
                    wr_en = 1'b1;
                    if (!txen)     wr_sym = SYM_T;
                    else if (txer) wr_sym = SYM_HALT;
                    else           wr_sym = data_code;
                end
                ST_SEND_R: begin
                    wr_en  = 1'b1;
                    wr_sym = SYM_R;
                end
                default: wr_en = 1'b0;
            endcase
        end
        ready_nx = link_sync && !wr_en && room_ok;
    end
endmodule

// File: rtl/mii_4b5b_tx_enc.sv
module mii_4b5b_tx_enc
    import mii_tx_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int HEADROOM   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             link_sync,
    input  logic [NIB_W-1:0] mac_txd,
    input  logic             mac_txen,
    input  logic             mac_txer,
    output logic             mac_ready,
    input  logic             rd_strobe,
    output logic [SYM_W-1:0] sym_out,
    output logic             sym_valid
);
    localparam int LW = $clog2(FIFO_DEPTH) + 1;
    localparam logic [LW-1:0] LEVEL_LIM = LW'(FIFO_DEPTH - HEADROOM);

    logic [SYM_W-1:0] data_code;
    logic             sym_wr;
    logic [SYM_W-1:0] sym_wdata;
    logic [LW-1:0]    fifo_level;
    logic [LW-1:0]    fifo_level_nx;
    logic             fifo_empty;
    logic             room_ok;
    tx_state_t        fsm_state;

    assign room_ok   = (fifo_level_nx <= LEVEL_LIM);
    assign sym_valid = !fifo_empty;

    nibble_4b5b u_map (
        .nib  (mac_txd),
        .code (data_code)
    );

    mii_tx_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .link_sync (link_sync),
        .txen      (mac_txen),
        .txer      (mac_txer),
        .data_code (data_code),
        .room_ok   (room_ok),
        .ready     (mac_ready),
        .wr_en     (sym_wr),
        .wr_sym    (sym_wdata),
        .state     (fsm_state)
    );

    sym_fifo #(
        .W         (SYM_W),
        .DEPTH     (FIFO_DEPTH),
        .EMPTY_VAL (SYM_IDLE)
    ) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (sym_wr),
        .wr_data  (sym_wdata),
        .rd_en    (rd_strobe),
        .rd_data  (sym_out),
        .empty    (fifo_empty),
        .level    (fifo_level),
        .level_nx (fifo_level_nx)
    );
endmodule

// File: rtl/mii_4b5b_tx_chk.sv
module mii_4b5b_tx_chk
    import mii_tx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LW    = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             link_sync,
    input logic             mac_txen,
    input logic             mac_txer,
    input logic             mac_ready,
    input logic [SYM_W-1:0] sym_out,
    input logic             sym_valid,
    input logic             wr_en,
    input logic [SYM_W-1:0] wr_sym,
    input logic [LW-1:0]    level,
    input tx_state_t        state
);
    p_ready_needs_sync_r2: assert property (@(posedge clk) disable iff (rst)
        !link_sync |=> !mac_ready);

    p_ready_drop_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !mac_ready);

    p_halt_sub_r6: assert property (@(posedge clk) disable iff (rst)
        (mac_ready && state == ST_PAYLOAD && mac_txen && mac_txer) |-> (wr_en && wr_sym == SYM_HALT));

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (level < LW'(DEPTH)));

    p_headroom_r9: assert property (@(posedge clk) disable iff (rst)
        mac_ready |-> (level <= LW'(DEPTH - 3)));

    p_idle_out_r10: assert property (@(posedge clk) disable iff (rst)
        !sym_valid |-> (sym_out == SYM_IDLE));
endmodule

bind mii_4b5b_tx_enc mii_4b5b_tx_chk #(
    .DEPTH (FIFO_DEPTH),
    .LW    (LW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .link_sync (link_sync),
    .mac_txen  (mac_txen),
    .mac_txer  (mac_txer),
    .mac_ready (mac_ready),
    .sym_out   (sym_out),
    .sym_valid (sym_valid),
    .wr_en     (sym_wr),
    .wr_sym    (sym_wdata),
    .level     (fifo_level),
    .state     (fsm_state)
);

// File: tb/sim_mii_4b5b_tx_enc.sv
`timescale 1ns/1ps
module sim_mii_4b5b_tx_enc;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       link_sync = 1'b0;
    logic [3:0] mac_txd = 4'h0;
    logic       mac_txen = 1'b0;
    logic       mac_txer = 1'b0;
    logic       mac_ready;
    logic       rd_strobe = 1'b0;
    logic [4:0] sym_out;
    logic       sym_valid;

    int checks = 0;
    int fails  = 0;
    int rx_cnt = 0;
    bit rd_allow = 1'b0;
    int bst = 0;
    logic [4:0] exp_q[$];

    always #4 clk = ~clk;

    mii_4b5b_tx_enc u0 (
        .clk(clk), .rst(rst), .link_sync(link_sync), .mac_txd(mac_txd),
        .mac_txen(mac_txen), .mac_txer(mac_txer), .mac_ready(mac_ready),
        .rd_strobe(rd_strobe), .sym_out(sym_out), .sym_valid(sym_valid)
    );

    function automatic logic [4:0] enc(input logic [3:0] n);
        logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                               5'b01010, 5'b01011, 5'b01110, 5'b01111,
                               5'b10010, 5'b10011, 5'b10110, 5'b10111,
                               5'b11010, 5'b11011, 5'b11100, 5'b11101};
        return t[n];
    endfunction

    function automatic string tag_of(input logic [4:0] s);
        if (s == 5'b11000 || s == 5'b10001) return "R4";
        if (s == 5'b01101 || s == 5'b00111) return "R7";
        if (s == 5'b00100) return "R6";
        return "R5";
    endfunction

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Downstream reader: decides the strobe at each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (rd_allow && ($urandom % 4 != 0)) begin
                if (sym_valid) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R10 unexpected symbol", int'(sym_out), 0);
                    end else begin
                        chk(sym_out == exp_q[0], {tag_of(exp_q[0]), " symbol order R10"},
                            int'(sym_out), int'(exp_q[0]));
                        void'(exp_q.pop_front());
                    end
                    rx_cnt++;
                end
                rd_strobe = 1'b1;
            end else begin
                rd_strobe = 1'b0;
            end
        end
    end

    // One MAC step: drive, hold until ready, model the written symbol.
    task automatic step(input bit en, input bit er, input logic [3:0] d);
        bit wr = 1'b0;
        logic [4:0] s = 5'b11111;
        mac_txen = en; mac_txer = er; mac_txd = d;
        while (!mac_ready) @(negedge clk);
        unique case (bst)
            0: if (en) begin wr = 1'b1; s = 5'b11000; bst = 1; end
            1: begin wr = 1'b1; s = 5'b10001; bst = 2; end
            2: begin
                wr = 1'b1;
                if (!en) begin s = 5'b01101; bst = 3; end
                else if (er) s = 5'b00100;
                else s = enc(d);
            end
            default: begin wr = 1'b1; s = 5'b00111; bst = 0; end
        endcase
        if (wr) exp_q.push_back(s);
        @(negedge clk);
        // Scramble held lines so a late sample would be noticed.
        mac_txd = 4'($urandom);
        if (wr) chk(mac_ready == 1'b0, "R3 ready low after write", int'(mac_ready), 0);
    endtask

    task automatic packet(input int n_en, input int err_mod);
        for (int i = 0; i < n_en; i++)
            step(1'b1, (i >= 2) && (err_mod > 0) && ($urandom % err_mod == 0), 4'($urandom));
        while (bst != 0) step(1'b0, 1'b0, 4'($urandom));
        step(1'b0, 1'b0, 4'($urandom));
    endtask

    task automatic drain();
        rd_allow = 1'b1;
        for (int i = 0; i < 200; i++) begin
            if (exp_q.size() == 0 && !sym_valid) break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int base;
        void'($urandom(32'd20240517));
        repeat (4) @(negedge clk);
        chk(mac_ready == 0, "R1 ready in reset", int'(mac_ready), 0);
        chk(sym_valid == 0, "R1 valid in reset", int'(sym_valid), 0);
        chk(sym_out == 5'b11111, "R1 idle symbol in reset", int'(sym_out), 5'h1f);
        rst = 1'b0;
        mac_txen = 1'b1;
        @(negedge clk);
        chk(mac_ready == 0, "R1 ready after reset", int'(mac_ready), 0);
        repeat (10) @(negedge clk);
        chk(mac_ready == 0, "R2 ready without sync", int'(mac_ready), 0);
        chk(sym_valid == 0, "R2 nothing written without sync", int'(sym_valid), 0);
        mac_txen = 1'b0;
        link_sync = 1'b1;
        @(negedge clk);
        chk(mac_ready == 1, "R2 ready after sync", int'(mac_ready), 1);
        chk(sym_out == 5'b11111 && !sym_valid, "R10 empty output", int'(sym_out), 5'h1f);
        rd_allow = 1'b1;

        // R8: enable for a single step, then for two steps.
        for (int n = 1; n <= 2; n++) begin
            base = rx_cnt;
            packet(n, 0);
            drain();
            chk(rx_cnt - base == 4, "R8 short packet gives J K T R", rx_cnt - base, 4);
            chk(exp_q.size() == 0, "R8 short packet complete", exp_q.size(), 0);
        end

        // R5 all nibbles in order, R6 error on one of them.
        step(1'b1, 1'b0, 4'h5);
        step(1'b1, 1'b1, 4'hA);
        for (int v = 0; v < 16; v++) step(1'b1, (v == 7), 4'(v));
        packet(0, 0);
        drain();
        chk(exp_q.size() == 0, "R5 R6 coded packet drained", exp_q.size(), 0);

        // R9: reader stopped, long packet fills the buffer to the limit.
        rd_allow = 1'b0;
        @(negedge clk);
        fork
            packet(20, 0);
            begin
                repeat (80) @(negedge clk);
                chk(exp_q.size() == 14, "R9 fill level at stall", exp_q.size(), 14);
                chk(mac_ready == 0, "R9 ready low near full", int'(mac_ready), 0);
                rd_allow = 1'b1;
            end
        join
        drain();
        chk(exp_q.size() == 0, "R9 nothing lost", exp_q.size(), 0);

        // Random packets with errored nibbles.
        for (int p = 0; p < 40; p++) begin
            packet(1 + int'($urandom % 12), 6);
            if ($urandom % 3 == 0) repeat ($urandom % 5) step(1'b0, 1'b0, 4'($urandom));
        end
        drain();
        chk(exp_q.size() == 0, "R10 random stream complete", exp_q.size(), 0);
        repeat (3) @(negedge clk);
        chk(sym_out == 5'b11111 && !sym_valid, "R10 idle after drain", int'(sym_out), 5'h1f);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule